// File: doc/BRIEF.md
# Two-Way Set-Associative Write-Back Byte Cache

This block is a small data cache that sits between a processor request port and a lower-level memory port. It holds 32 bytes arranged as four sets, each with two ways of one 4-byte block. The processor issues single-byte loads and stores on a 12-bit byte address through a valid/ready handshake. The block reports completion with a one-cycle response pulse.

On a hit the access is served in the cycle it is accepted, and the response follows on the next cycle. On a miss the block chooses a victim way inside the indexed set. If that victim holds modified data, the block first writes it back to memory as a whole block. It then reads the aligned block from memory and completes the load or store on the new copy. Each way carries its own valid bit, dirty bit and tag, and each set keeps one bit that names the way to evict next.

Top module: `sa2_cache`

## Requirements
- R1: An address splits into tag = addr[11:4], set index = addr[3:2] and byte offset = addr[1:0]. There are 4 sets of 2 ways, and each way holds one 4-byte block.
- R2: A request hits when either way of the indexed set is valid and its stored tag equals the address tag. A hit produces no memory transaction, and rsp_valid rises on the cycle after acceptance.
- R3: A given block occupies at most one way, so no two valid ways of one set ever match the same tag. Blocks that share a tag but sit at different indices are distinct and occupy different sets.
- R4: On a miss the victim is an invalid way if one exists, with way 0 tried before way 1. Otherwise the victim is the way named by the set's replacement bit.
- R5: Every hit and every fill sets the set's replacement bit to the way that was not touched.
- R6: If the victim is valid and dirty, the block first issues one memory write of its 4 bytes at address {victim tag, index, 2'b00}. The read follows only after that write. A clean or invalid victim causes no memory write.
- R7: A fill issues one memory read at {tag, index, 2'b00}. It then stores the tag, sets valid and leaves dirty clear for a load.
- R8: A store is write-allocate. After any fill it writes the byte at the offset and sets that way's dirty bit. For a store, rsp_rdata returns the byte written.
- R9: A load returns on rsp_rdata the byte at the offset, where offset k selects bits [8k+7:8k] of the block, after the fill when the access missed.
- R10: req_ready is high only when the block is idle. It stays low from the acceptance of a missing request until that request completes. While mem_valid is high and mem_ready is low, mem_addr and mem_write hold steady.
- R11: Reset clears all valid, dirty and replacement bits, so every first access after reset misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Block can accept a request (idle) |
| req_write | input | 1 | 1 = store byte, 0 = load byte |
| req_addr | input | 12 | Byte address |
| req_wdata | input | 8 | Store data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Loaded byte, or the byte stored |
| mem_valid | output | 1 | Memory transaction requested |
| mem_ready | input | 1 | Memory completes the transaction this cycle |
| mem_write | output | 1 | 1 = block write-back, 0 = block read |
| mem_addr | output | 12 | Block-aligned memory address |
| mem_wdata | output | 32 | Block being written back |
| mem_rdata | input | 32 | Block read data, valid when mem_ready is high |

## Verification
The bench builds the block with its default geometry: a 12-bit address, four sets and 4-byte blocks. At this size a model of one tag byte per way is easy to track, and a bench memory that covers the whole 4 KiB address space fits comfortably. Random requests draw tags from a pool of only six values. That keeps every set under pressure, so the run reaches repeated hits, evictions of dirty and clean victims, and the preference for an invalid way. A random memory ready signal stretches the write-back and fill phases.

// File: rtl/sa2_cache_pkg.sv
package sa2_cache_pkg;

    localparam int WAYS   = 2;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_EVICT = 2'd1,
        PH_FILL  = 2'd2
    } phase_e;

endpackage

// File: rtl/sa2_cache_match.sv
module sa2_cache_match #(
    parameter int TAG_W = 8,
    parameter int WAYS  = 2,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [WAYS-1:0]             way_vld,
    input  logic [WAYS-1:0][TAG_W-1:0]  way_tag,
    input  logic [TAG_W-1:0]            look_tag,
    output logic                        hit,
    output logic [WAY_W-1:0]            hit_way
);

    logic [WAYS-1:0] eq;

    generate
        for (genvar w = 0; w < WAYS; w++) begin : g_way
            assign eq[w] = way_vld[w] && (way_tag[w] == look_tag);
        end
    endgenerate

    always_comb begin
        hit     = |eq;
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (eq[w]) hit_way = WAY_W'(w);
        end
    end

    // R3: a block never lives in two ways of the same set
    assert_single_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(eq));

endmodule

// File: rtl/sa2_cache_victim.sv
module sa2_cache_victim #(
    parameter int WAYS = 2
) (
    input  logic [WAYS-1:0] way_vld,
    input  logic            lru_way,
    output logic            victim
);

    generate
        if (WAYS == 2) begin : g_two
            always_comb begin
                if (!way_vld[0])      victim = 1'b0;
                else if (!way_vld[1]) victim = 1'b1;
                else                  victim = lru_way;
            end
        end else begin : g_other
            assign victim = lru_way;
        end
    endgenerate

endmodule

// File: rtl/sa2_cache.sv
module sa2_cache #(
    parameter int ADDR_W    = 12,
    parameter int NUM_SETS  = 4,
    parameter int BLK_BYTES = 4,
    localparam int OFF_W = $clog2(BLK_BYTES),
    localparam int IDX_W = $clog2(NUM_SETS),
    localparam int TAG_W = ADDR_W - IDX_W - OFF_W,
    localparam int BLK_W = BLK_BYTES * 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [7:0]        req_wdata,
    output logic              rsp_valid,
    output logic [7:0]        rsp_rdata,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic              mem_write,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BLK_W-1:0]  mem_wdata,
    input  logic [BLK_W-1:0]  mem_rdata
);
    import sa2_cache_pkg::*;

    typedef struct packed {
        phase_e                                   phase;
        logic [NUM_SETS-1:0][WAYS-1:0]            vld;
        logic [NUM_SETS-1:0][WAYS-1:0]            dty;
        logic [NUM_SETS-1:0][WAYS-1:0][TAG_W-1:0] tag;
        logic [NUM_SETS-1:0][WAYS-1:0][BLK_W-1:0] dat;
        logic [NUM_SETS-1:0]                      lru;
        logic                                     p_wr;
        logic [ADDR_W-1:0]                        p_addr;
        logic [7:0]                               p_wdata;
        logic                                     p_way;
        logic                                     rsp_vld;
        logic [7:0]                               rsp_byte;
    } state_t;

    state_t st_d, st_q;

    function automatic logic [BLK_W-1:0] put_byte(input logic [BLK_W-1:0] blk,
                                                  input logic [OFF_W-1:0] off,
                                                  input logic [7:0]       b);
        put_byte = blk;
        for (int i = 0; i < BLK_BYTES; i++)
            if (off == OFF_W'(i)) put_byte[i*8 +: 8] = b;
    endfunction

    function automatic logic [7:0] get_byte(input logic [BLK_W-1:0] blk,
                                            input logic [OFF_W-1:0] off);
        get_byte = '0;
        for (int i = 0; i < BLK_BYTES; i++)
            if (off == OFF_W'(i)) get_byte = blk[i*8 +: 8];
    endfunction

    // request address fields
    logic [OFF_W-1:0] a_off;
    logic [IDX_W-1:0] a_idx;
    logic [TAG_W-1:0] a_tag;
    assign a_off = req_addr[OFF_W-1:0];
    assign a_idx = req_addr[OFF_W +: IDX_W];
    assign a_tag = req_addr[ADDR_W-1 -: TAG_W];

    // pending miss fields
    logic [OFF_W-1:0] p_off;
    logic [IDX_W-1:0] p_idx;
    logic [TAG_W-1:0] p_tag;
    assign p_off = st_q.p_addr[OFF_W-1:0];
    assign p_idx = st_q.p_addr[OFF_W +: IDX_W];
    assign p_tag = st_q.p_addr[ADDR_W-1 -: TAG_W];

    logic hit, hit_way, victim;

    sa2_cache_match #(.TAG_W(TAG_W), .WAYS(WAYS)) u_match (
        .clk      (clk),
        .rst_n    (rst_n),
        .way_vld  (st_q.vld[a_idx]),
        .way_tag  (st_q.tag[a_idx]),
        .look_tag (a_tag),
        .hit      (hit),
        .hit_way  (hit_way)
    );

    sa2_cache_victim #(.WAYS(WAYS)) u_victim (
        .way_vld (st_q.vld[a_idx]),
        .lru_way (st_q.lru[a_idx]),
        .victim  (victim)
    );

    always_comb begin
        logic [BLK_W-1:0] blk;
        st_d         = st_q;
        st_d.rsp_vld = 1'b0;
        blk          = '0;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (req_valid) begin
                    st_d.p_wr    = req_write;
                    st_d.p_addr  = req_addr;
                    st_d.p_wdata = req_wdata;
                    if (hit) begin
                        blk = st_q.dat[a_idx][hit_way];
                        if (req_write) begin
                            st_d.dat[a_idx][hit_way] = put_byte(blk, a_off, req_wdata);
                            st_d.dty[a_idx][hit_way] = 1'b1;
                            st_d.rsp_byte            = req_wdata;
                        end else begin
                            st_d.rsp_byte = get_byte(blk, a_off);
                        end
                        st_d.lru[a_idx] = ~hit_way;
                        st_d.rsp_vld    = 1'b1;
                    end else begin
                        st_d.p_way = victim;
                        st_d.phase = (st_q.vld[a_idx][victim] && st_q.dty[a_idx][victim])
                                     ? PH_EVICT : PH_FILL;
                    end
                end
            end
            PH_EVICT: begin
                if (mem_ready) st_d.phase = PH_FILL;
            end
            PH_FILL: begin
                if (mem_ready) begin
                    blk = mem_rdata;
                    if (st_q.p_wr) begin
                        blk           = put_byte(blk, p_off, st_q.p_wdata);
                        st_d.rsp_byte = st_q.p_wdata;
                    end else begin
                        st_d.rsp_byte = get_byte(blk, p_off);
                    end
                    st_d.dat[p_idx][st_q.p_way] = blk;
                    st_d.tag[p_idx][st_q.p_way] = p_tag;
                    st_d.vld[p_idx][st_q.p_way] = 1'b1;
                    st_d.dty[p_idx][st_q.p_way] = st_q.p_wr;
                    st_d.lru[p_idx]             = ~st_q.p_way;
                    st_d.rsp_vld                = 1'b1;
                    st_d.phase                  = PH_IDLE;
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign req_ready = (st_q.phase == PH_IDLE);
    assign rsp_valid = st_q.rsp_vld;
    assign rsp_rdata = st_q.rsp_byte;
    assign mem_valid = (st_q.phase != PH_IDLE);
    assign mem_write = (st_q.phase == PH_EVICT);
    assign mem_addr  = (st_q.phase == PH_EVICT)
                       ? {st_q.tag[p_idx][st_q.p_way], p_idx, {OFF_W{1'b0}}}
                       : {p_tag, p_idx, {OFF_W{1'b0}}};
    assign mem_wdata = st_q.dat[p_idx][st_q.p_way];

    // R2: a hit answers on the next cycle with no memory traffic
    assert_hit_reply_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && hit) |=> (rsp_valid && !mem_valid));

    // R6: a completed write-back is followed by the block read
    assert_evict_then_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_ready && mem_write) |=> (mem_valid && !mem_write));

    // R7: a completed fill finishes the access on the next cycle
    assert_fill_reply_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_ready && !mem_write) |=> (rsp_valid && req_ready));

    // R10: a waiting memory request is held and the processor is stalled
    assert_hold_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr)
                                       && $stable(mem_write) && !req_ready));

endmodule

// File: tb/sa2_cache_bench.sv
`timescale 1ns/1ps
module sa2_cache_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [11:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        rsp_valid;
    logic [7:0]  rsp_rdata;
    logic        mem_valid;
    logic        mem_ready = 1'b0;
    logic        mem_write;
    logic [11:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata;

    always #10 clk = ~clk;   // 50 MHz

    sa2_cache u_sa2_cache (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_write(mem_write),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // ---------------- memory model ----------------
    logic [7:0]  mem [0:4095];
    int          wr_cnt = 0, rd_cnt = 0;
    logic [11:0] last_wr_addr = '0, last_rd_addr = '0;
    logic [31:0] last_wr_data = '0;

    assign mem_rdata = {mem[{mem_addr[11:2], 2'd3}], mem[{mem_addr[11:2], 2'd2}],
                        mem[{mem_addr[11:2], 2'd1}], mem[{mem_addr[11:2], 2'd0}]};

    always @(posedge clk) begin
        if (rst_n && mem_valid && mem_ready) begin
            if (mem_write) begin
                for (int b = 0; b < 4; b++)
                    mem[{mem_addr[11:2], 2'(b)}] <= mem_wdata[b*8 +: 8];
                wr_cnt       <= wr_cnt + 1;
                last_wr_addr <= mem_addr;
                last_wr_data <= mem_wdata;
            end else begin
                rd_cnt       <= rd_cnt + 1;
                last_rd_addr <= mem_addr;
            end
        end
    end

    always @(negedge clk) mem_ready <= (($urandom % 3) == 0);

    // ---------------- reference model ----------------
    logic        m_vld [4][2];
    logic        m_dty [4][2];
    logic [7:0]  m_tag [4][2];
    logic [31:0] m_dat [4][2];
    logic        m_lru [4];

    int vectors = 0, misses = 0;

    function automatic logic [7:0] init_byte(input int a);
        return 8'((a * 37) ^ (a >> 5) ^ 8'h5A);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            misses++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic access(input bit wr, input logic [11:0] a, input logic [7:0] wd);
        logic [1:0]  idx = a[3:2];
        logic [7:0]  tg  = a[11:4];
        logic [1:0]  off = a[1:0];
        bit          hit = 1'b0;
        int          way = 0;
        bit          exp_wb;
        logic [11:0] wb_addr, fill_addr;
        logic [31:0] wb_data, blk;
        logic [7:0]  exp_rd;
        int          wr0, rd0, lat;
        bit          busy_ok;

        for (int w = 0; w < 2; w++)
            if (m_vld[idx][w] && m_tag[idx][w] == tg) begin hit = 1'b1; way = w; end
        if (!hit) way = !m_vld[idx][0] ? 0 : (!m_vld[idx][1] ? 1 : int'(m_lru[idx]));
        exp_wb    = !hit && m_vld[idx][way] && m_dty[idx][way];
        wb_addr   = {m_tag[idx][way], idx, 2'b00};
        wb_data   = m_dat[idx][way];
        fill_addr = {tg, idx, 2'b00};

        @(negedge clk);
        chk(req_ready === 1'b1, "R10 ready when idle", 32'(req_ready), 32'd1);
        wr0 = wr_cnt; rd0 = rd_cnt;
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 0; busy_ok = 1'b1;
        while (rsp_valid !== 1'b1 && lat < 400) begin
            if (req_ready !== 1'b0) busy_ok = 1'b0;
            lat++;
            @(negedge clk);
        end
        if (lat >= 400) begin
            chk(1'b0, "watchdog: no response", 32'(lat), 32'd0);
            return;
        end

        if (hit) begin
            blk = m_dat[idx][way];
            chk(lat == 0, "R2 hit latency", 32'(lat), 32'd0);
            chk(wr_cnt == wr0 && rd_cnt == rd0, "R2 no memory traffic on hit",
                32'(wr_cnt - wr0 + rd_cnt - rd0), 32'd0);
        end else begin
            blk = {mem[fill_addr + 3], mem[fill_addr + 2], mem[fill_addr + 1], mem[fill_addr]};
            chk(busy_ok, "R10 ready low during miss", 32'(busy_ok), 32'd1);
            chk(wr_cnt - wr0 == int'(exp_wb), "R6 write-back count",
                32'(wr_cnt - wr0), 32'(exp_wb));
            if (exp_wb) begin
                chk(last_wr_addr == wb_addr, "R6 write-back address", 32'(last_wr_addr), 32'(wb_addr));
                chk(last_wr_data == wb_data, "R6 write-back data", last_wr_data, wb_data);
            end
            chk(rd_cnt - rd0 == 1, "R7 one fill read", 32'(rd_cnt - rd0), 32'd1);
            chk(last_rd_addr == fill_addr, "R1 R7 fill address", 32'(last_rd_addr), 32'(fill_addr));
            m_tag[idx][way] = tg;
            m_vld[idx][way] = 1'b1;
            m_dty[idx][way] = 1'b0;
        end

        if (wr) begin
            blk[off*8 +: 8] = wd;
            m_dty[idx][way] = 1'b1;
            exp_rd = wd;
            chk(rsp_rdata == exp_rd, "R8 store response byte", 32'(rsp_rdata), 32'(exp_rd));
        end else begin
            exp_rd = blk[off*8 +: 8];
            chk(rsp_rdata == exp_rd, "R9 load byte", 32'(rsp_rdata), 32'(exp_rd));
        end
        m_dat[idx][way] = blk;
        m_lru[idx]      = (way == 0);
        @(negedge clk);
        chk(rsp_valid === 1'b0, "R2 response is one pulse", 32'(rsp_valid), 32'd0);
    endtask

    initial begin : main
        void'($urandom(32'd2718));
        for (int i = 0; i < 4096; i++) mem[i] = init_byte(i);
        for (int s = 0; s < 4; s++) begin
            m_lru[s] = 1'b0;
            for (int w = 0; w < 2; w++) begin
                m_vld[s][w] = 1'b0; m_dty[s][w] = 1'b0;
                m_tag[s][w] = '0;   m_dat[s][w] = '0;
            end
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready === 1'b1, "R11 ready after reset", 32'(req_ready), 32'd1);
        chk(rsp_valid === 1'b0, "R11 no response after reset", 32'(rsp_valid), 32'd0);
        chk(mem_valid === 1'b0, "R11 memory idle after reset", 32'(mem_valid), 32'd0);

        // directed: cold misses, invalid-way preference, shared tag across sets
        access(1'b0, 12'hFE2, 8'h00);   // R11 first access misses
        access(1'b1, 12'h61C, 8'hA5);   // R8 store miss, set 3 way 0
        access(1'b0, 12'h61B, 8'h00);   // R3 same tag, set 2
        access(1'b0, 12'hCAD, 8'h00);   // R4 invalid way 1 taken in set 3
        access(1'b0, 12'h61C, 8'h00);   // R4 R8 hit on stored byte
        access(1'b0, 12'h33C, 8'h00);   // R5 evicts clean 0xCA way
        access(1'b0, 12'h44E, 8'h00);   // R6 evicts dirty 0x61 block
        access(1'b0, 12'h61F, 8'h00);   // R6 refetch returns written-back data
        access(1'b1, 12'h61D, 8'h3C);   // R8 store hit
        access(1'b0, 12'h61D, 8'h00);   // R9 byte lane 1

        // random mix on a small tag pool
        for (int n = 0; n < 1500; n++) begin
            logic [7:0] t = 8'(8'h20 + 8'h11 * ($urandom % 6));
            access(($urandom % 5) < 2, {t, 2'($urandom), 2'($urandom)}, 8'($urandom));
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin : watchdog
        #(20 * 190000);
        misses++;
        $display("FAIL watchdog: run did not finish actual=0 expected=1");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule